// File: doc/BRIEF.md
# Fractional DAC Reference Ramp Generator

This block slews a 14-bit DAC reference word from a programmed start value to a programmed end value. The 14-bit word is a 10-bit converter code with 4 dither bits below it, so both ends of a ramp may sit on fractional codes. A start command loads the start value. From then on each step adds or subtracts an unsigned 18-bit step word. The direction is chosen from how the start value compares with the end value. Each step waits for a programmable number of one-clock switching-cycle trigger pulses.

The position is held with 10 hidden fractional bits below the dither LSB, which carry into the visible word. A very small step therefore gives a very slow ramp. The last step is clamped to the end value exactly. A done flag then rises and the output holds until the next start command. All pins are plain control and status levels or pulses. No stream interface is involved, so there is no back-pressure.

Top module: `ramp_ref_gen`

## Requirements
- R1: One clock after `go` is sampled high, `dac_value` equals `start_value`, the hidden fraction is zero and the trigger count restarts from zero. `done` is low unless start equals end.
- R2: If `start_value` equals `end_value` at `go`, `done` is high one clock later and `dac_value` never moves.
- R3: With `cycles_per_step` = N (7 bits, 0 to 127), a step is taken on the (N+1)-th trigger pulse counted since the last step or `go`. N = 0 steps on every pulse.
- R4: If start is below end, each step adds `step_size`. If start is above end, each step subtracts it. The output moves monotonically in that direction.
- R5: The position is `{dac_value, frac[9:0]}`. The step is added at bit 0 of this position, so step bits 17:10 align with `dac_value` bits 7:0 and step bits 9:0 are fractional. For example, step 0x100 leaves `dac_value` at its start for three steps and raises it by 1 on the fourth.
- R6: A step that would reach or pass the end value sets `dac_value` to the end value exactly and clears the fraction. `done` rises in the same clock.
- R7: While `done` is high, trigger pulses are ignored: `dac_value` and `done` hold until the next `go`.
- R8: When `go` and `trig` are high in the same cycle, `go` wins. That trigger is not counted.
- R9: After reset, `dac_value` is 0 and `done` is 0, and triggers have no effect until `go`.
- R10: `dac_value` changes only on a clock where `go` or a counted trigger is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start command pulse; loads start and arms the ramp |
| trig | input | 1 | One-clock switching-cycle trigger pulse |
| start_value | input | 14 | Ramp start code (10-bit code plus 4 dither bits) |
| end_value | input | 14 | Ramp end code, captured at `go` |
| step_size | input | 18 | Unsigned step; bits 9:0 fractional |
| cycles_per_step | input | 7 | Trigger pulses per step minus one |
| dac_value | output | 14 | Current reference code |
| done | output | 1 | High once the end value is reached |

## Verification
A start command and a trigger pulse can arrive in the same cycle. The trigger may also be the one that would complete the pending step. The bench drives coincident `go` and `trig` directly and also at random points in random ramps. A reference model in the bench gives `go` priority and restarts its own count. The model is compared with `dac_value` and `done` on every cycle, so a counted stale trigger shows up as a step one pulse early.

// File: rtl/ramp_ref_pkg.sv
package ramp_ref_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} ramp_dir_e;
endpackage

// File: rtl/ramp_ref_pacer.sv
module ramp_ref_pacer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic             trig,
  input  logic [CNT_W-1:0] limit,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q;
  logic             counted;

  assign counted = enable && trig && !clear;
  assign fire    = counted && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (fire)    cnt_q <= '0;
    else if (counted) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ramp_ref_stepper.sv
module ramp_ref_stepper
  import ramp_ref_pkg::*;
#(
  parameter int DAC_W  = 14,
  parameter int FRAC_W = 10,
  parameter int STEP_W = 18
) (
  input  logic [DAC_W+FRAC_W-1:0] pos,
  input  logic [STEP_W-1:0]       step,
  input  logic [DAC_W-1:0]        target,
  input  ramp_dir_e               dir,
  output logic [DAC_W+FRAC_W-1:0] pos_next,
  output logic                    hit
);
  localparam int POS_W = DAC_W + FRAC_W;

  logic [POS_W:0] step_ext, tgt_ext, sum_up, diff_dn;

  assign step_ext = {{(POS_W + 1 - STEP_W){1'b0}}, step};
  assign tgt_ext  = {1'b0, target, {FRAC_W{1'b0}}};
  assign sum_up   = {1'b0, pos} + step_ext;
  assign diff_dn  = {1'b0, pos} - step_ext;

  always_comb begin
    if (dir == DIR_UP) begin
      hit      = (sum_up >= tgt_ext);
      pos_next = hit ? tgt_ext[POS_W-1:0] : sum_up[POS_W-1:0];
    end else begin
      hit      = diff_dn[POS_W] || (diff_dn <= tgt_ext);
      pos_next = hit ? tgt_ext[POS_W-1:0] : diff_dn[POS_W-1:0];
    end
  end
endmodule

// File: rtl/ramp_ref_gen.sv
module ramp_ref_gen
  import ramp_ref_pkg::*;
#(
  parameter int DAC_W  = 14,
  parameter int FRAC_W = 10,
  parameter int STEP_W = 18,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              trig,
  input  logic [DAC_W-1:0]  start_value,
  input  logic [DAC_W-1:0]  end_value,
  input  logic [STEP_W-1:0] step_size,
  input  logic [CNT_W-1:0]  cycles_per_step,
  output logic [DAC_W-1:0]  dac_value,
  output logic              done
);
  localparam int POS_W = DAC_W + FRAC_W;

  logic [POS_W-1:0] pos_q, pos_next;
  logic [DAC_W-1:0] end_q;
  ramp_dir_e        dir_q;
  logic             busy_q, done_q;
  logic             fire, hit;

  ramp_ref_pacer #(.CNT_W(CNT_W)) u_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (go),
    .enable (busy_q),
    .trig   (trig),
    .limit  (cycles_per_step),
    .fire   (fire)
  );

  ramp_ref_stepper #(.DAC_W(DAC_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_stepper (
    .pos      (pos_q),
    .step     (step_size),
    .target   (end_q),
    .dir      (dir_q),
    .pos_next (pos_next),
    .hit      (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      end_q  <= '0;
      dir_q  <= DIR_UP;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (go) begin
      pos_q  <= {start_value, {FRAC_W{1'b0}}};
      end_q  <= end_value;
      dir_q  <= (start_value < end_value) ? DIR_UP : DIR_DOWN;
      busy_q <= (start_value != end_value);
      done_q <= (start_value == end_value);
    end else if (fire) begin
      pos_q <= pos_next;
      if (hit) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign dac_value = pos_q[POS_W-1 -: DAC_W];
  assign done      = done_q;
endmodule

// File: rtl/ramp_ref_gen_chk.sv
module ramp_ref_gen_chk #(
  parameter int DAC_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             trig,
  input logic [DAC_W-1:0] start_value,
  input logic [DAC_W-1:0] end_value,
  input logic [DAC_W-1:0] dac_value,
  input logic             done,
  input logic             busy,
  input logic             up,
  input logic [DAC_W-1:0] end_q
);
  assert_load_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> dac_value == $past(start_value));

  assert_equal_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go && (start_value == end_value) |=> done);

  assert_up_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && up && !go |=> dac_value >= $past(dac_value));

  assert_down_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !up && !go |=> dac_value <= $past(dac_value));

  assert_done_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> dac_value == end_q);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !go |=> done && $stable(dac_value));

  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !go && !trig |=> $stable(dac_value));
endmodule

bind ramp_ref_gen ramp_ref_gen_chk #(.DAC_W(DAC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .go          (go),
  .trig        (trig),
  .start_value (start_value),
  .end_value   (end_value),
  .dac_value   (dac_value),
  .done        (done),
  .busy        (busy_q),
  .up          (dir_q == ramp_ref_pkg::DIR_UP),
  .end_q       (end_q)
);

// File: tb/ramp_ref_gen_test.sv
`timescale 1ns/1ps
module ramp_ref_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0, trig = 1'b0;
  logic [13:0] start_value = '0, end_value = '0;
  logic [17:0] step_size = '0;
  logic [6:0]  cycles_per_step = '0;
  logic [13:0] dac_value;
  logic        done;

  int checks = 0, errors = 0;
  longint m_pos, m_end;
  int m_cnt;
  bit m_up, m_busy, m_done;

  always #2.5 clk = ~clk;

  ramp_ref_gen uut (.*);

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model, updated for the inputs sampled at a rising edge
  task automatic model_edge();
    longint n;
    if (go) begin
      m_pos = longint'(start_value) << 10; m_end = longint'(end_value) << 10;
      m_cnt = 0; m_up = start_value < end_value;
      m_busy = start_value != end_value; m_done = !m_busy;
    end else if (trig && m_busy) begin
      if (m_cnt == int'(cycles_per_step)) begin
        m_cnt = 0;
        n = m_up ? m_pos + step_size : m_pos - step_size;
        if ((m_up && n >= m_end) || (!m_up && n <= m_end)) begin
          m_pos = m_end; m_busy = 0; m_done = 1;
        end else m_pos = n;
      end else m_cnt++;
    end
  endtask

  // drive after falling edge, step one clock, compare after next falling edge
  task automatic tick(input bit g, input bit t, input string tag);
    go = g; trig = t;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    go = 0; trig = 0;
    check({tag, " dac"}, dac_value, m_pos >> 10);
    check({tag, " done"}, done, m_done);
  endtask

  task automatic launch(input int s, input int e, input int st, input int c, input string tag);
    start_value = 14'(s); end_value = 14'(e); step_size = 18'(st); cycles_per_step = 7'(c);
    tick(1, 0, tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_pos = 0; m_end = 0; m_cnt = 0; m_up = 1; m_busy = 0; m_done = 0;
    repeat (3) @(negedge clk);
    check("R9 reset dac", dac_value, 0);
    check("R9 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    tick(0, 1, "R9 trig before go");
    tick(0, 1, "R9 trig before go");

    // R5: step 0x100, DAC rises by 1 on fourth step
    launch(0, 100 * 16, 'h100, 0, "R1 load");
    for (int i = 1; i <= 4; i++) begin
      tick(0, 1, "R5 fraction carry");
      check("R5 step value", dac_value, (i == 4) ? 1 : 0);
    end

    // R3: cycles_per_step = 3 needs four pulses
    launch(200, 300, 'h400, 3, "R1 reload");
    for (int i = 1; i <= 4; i++) begin
      tick(0, 1, "R3 pacing");
      check("R3 pacing value", dac_value, (i == 4) ? 201 : 200);
    end
    tick(0, 0, "R10 no trigger");

    // R4/R6: down ramp with clamp at end
    launch(1000, 995, 'h1000, 0, "R4 down load");
    tick(0, 1, "R4 down step");
    check("R4 down value", dac_value, 996);
    tick(0, 1, "R6 clamp down");
    check("R6 clamp exact", dac_value, 995);
    check("R6 done raised", done, 1);
    // R7: triggers ignored after done
    repeat (5) tick(0, 1, "R7 idle trig");
    check("R7 hold end", dac_value, 995);

    // R6: up overshoot clamp
    launch(16380, 16383, 'h3FFFF, 0, "R6 up load");
    tick(0, 1, "R6 clamp up");
    check("R6 up clamp", dac_value, 16383);

    // R2: start equals end
    launch(77, 77, 'h400, 0, "R2 equal");
    check("R2 done immediately", done, 1);
    tick(0, 1, "R2 no step");
    check("R2 value held", dac_value, 77);

    // R8: go and trig together, go wins and count restarts
    start_value = 10; end_value = 50; step_size = 'h400; cycles_per_step = 1;
    tick(1, 0, "R8 arm");
    tick(0, 1, "R8 first pulse");
    tick(1, 1, "R8 coincident go");
    check("R8 go wins", dac_value, 10);
    tick(0, 1, "R8 count restarted");
    check("R8 no early step", dac_value, 10);
    tick(0, 1, "R8 second pulse");
    check("R8 step after two", dac_value, 11);

    // random ramps
    for (int r = 0; r < 24; r++) begin
      int guard;
      launch(int'($urandom % 16384), int'($urandom % 16384),
             int'(18'h20000 + ($urandom % 18'h20000)), int'($urandom % 4), "R4 random load");
      guard = 0;
      while (!m_done && guard < 2000) begin
        bit g = ($urandom % 200) == 0;
        bit t = ($urandom % 2) == 1;
        if (g) tick(1, 1, "R8 random coincident");
        else   tick(0, t, "R4 R6 random ramp");
        guard++;
      end
      repeat (3) tick(0, 1, "R7 random idle");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule